// File: doc/BRIEF.md
# Keyed Indexed Configuration Port

This block holds a small configuration register space that a host reaches through two byte-wide ports on a simple bus. Address 0 is the index port and address 1 is the data port. The host writes a register number to the index port, then reads or writes that register through the data port. Reads have no side effects.

The space starts locked after reset. It opens only when an unlock key is written to the index port on two consecutive bus writes, and a lock key closes it again. While the space is locked, every read returns 0xFF. Registers below 0x30 are global. They hold a device-select register, read-only chip and vendor identifiers (each split into a high byte and a low byte) and a read/write port-select byte. Registers at 0x30 and above belong to the logical device picked by the device-select register. Each device has its own enable, base-address high, base-address low and interrupt-select bytes.

Top module: `cfg_index_port`

## Requirements
- R1: The space opens only after the unlock key (0x87) is written to the index port (busAddr=0) on two consecutive bus writes. After only one key write, reads still return 0xFF.
- R2: While the space is not open, the unlock sequence starts over after a non-key write to the index port, or after any write to the data port (busAddr=1), made between the two key writes.
- R3: Writing the lock key (0xAA) to the index port while open closes the space in the next cycle.
- R4: While the space is not open, busRdata is 0xFF on both ports, and data-port writes change no register.
- R5: While open, a read of the index port returns the last index written. The first unlock leaves the index at 0x00 from reset.
- R6: The global registers are chip ID high at 0x20 and low at 0x21, and vendor ID high at 0x23 and low at 0x24. These are read-only. Port select is read/write at 0x26. Global registers read the same whichever device is selected.
- R7: The device-select register at 0x07 chooses which device bank answers every later access at index 0x30 or above.
- R8: Each device bank keeps an enable byte (0x30), base-address high (0x60), base-address low (0x61) and interrupt select (0x70). Each reads back the full byte written, independently of the other banks.
- R9: When device select is NUM_DEV or more, banked reads return 0xFF and banked writes change nothing.
- R10: Unimplemented indices read 0x00, and writes to them have no effect.
- R11: When busRd is low, busRdata is 0xFF. Reads never change state.
- R12: After reset the space is locked, the index is 0x00, device select is 0, port select is 0x00 and every bank register is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 1 | 0 selects the index port, 1 the data port |
| busWr | input | 1 | Write strobe, one write per cycle |
| busRd | input | 1 | Read strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational from state and address |

## Verification
A wrong unlock state shows up as soon as the next read: a port that opens early returns a register value where 0xFF is expected, and one that fails to open returns 0xFF. A wrong index or device select appears on the first data-port read after the write that set it, as the value of another register or another bank. A lost or misdirected write stays hidden until that register is read back. For this reason, the stimulus reads every bank after all banks have been written.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_HALF   = 2'd1,
    ST_OPEN   = 2'd2
  } unlock_e;

  typedef struct packed {
    logic open;
    logic idxLoad;
    logic dataWr;
  } cfg_strobe_t;

  localparam logic [7:0] IDX_DEVSEL   = 8'h07;
  localparam logic [7:0] IDX_CHIP_HI  = 8'h20;
  localparam logic [7:0] IDX_CHIP_LO  = 8'h21;
  localparam logic [7:0] IDX_VEND_HI  = 8'h23;
  localparam logic [7:0] IDX_VEND_LO  = 8'h24;
  localparam logic [7:0] IDX_PORTSEL  = 8'h26;
  localparam logic [7:0] IDX_BANK_LO  = 8'h30;
  localparam logic [7:0] IDX_DEV_EN   = 8'h30;
  localparam logic [7:0] IDX_BASE_HI  = 8'h60;
  localparam logic [7:0] IDX_BASE_LO  = 8'h61;
  localparam logic [7:0] IDX_IRQ_SEL  = 8'h70;
  localparam int         BANK_SLOTS   = 4;
endpackage

// File: rtl/cfg_ctrl.sv
module cfg_ctrl
  import cfgport_pkg::*;
#(
  parameter logic [7:0] UNLOCK_KEY = 8'h87,
  parameter logic [7:0] LOCK_KEY   = 8'hAA
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busAddr,
  input  logic        busWr,
  input  logic [7:0]  busWdata,
  output cfg_strobe_t strb
);
  unlock_e state, stateNxt;
  logic idxWr, dataWrIn;

  assign idxWr    = busWr && !busAddr;
  assign dataWrIn = busWr && busAddr;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_LOCKED: if (idxWr && busWdata == UNLOCK_KEY) stateNxt = ST_HALF;
      ST_HALF: begin
        if (idxWr) stateNxt = (busWdata == UNLOCK_KEY) ? ST_OPEN : ST_LOCKED;
        else if (dataWrIn) stateNxt = ST_LOCKED;
      end
      ST_OPEN: if (idxWr && busWdata == LOCK_KEY) stateNxt = ST_LOCKED;
      default: stateNxt = ST_LOCKED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_LOCKED;
    else       state <= stateNxt;
  end

  always_comb begin
    strb.open    = (state == ST_OPEN);
    strb.idxLoad = (state == ST_OPEN) && idxWr && (busWdata != LOCK_KEY);
    strb.dataWr  = (state == ST_OPEN) && dataWrIn;
  end
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import cfgport_pkg::*;
#(
  parameter int          NUM_DEV      = 4,
  parameter logic [15:0] CHIP_ID      = 16'h3C15,
  parameter logic [15:0] VENDOR_ID    = 16'h5A70,
  parameter logic [7:0]  PORT_SEL_RST = 8'h00
) (
  input  logic        clk,
  input  logic        rstN,
  input  cfg_strobe_t strb,
  input  logic        busAddr,
  input  logic        busRd,
  input  logic [7:0]  busWdata,
  output logic [7:0]  busRdata
);
  localparam int DEV_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

  logic [7:0] idxReg, devSel, portSel;
  logic [BANK_SLOTS-1:0][7:0] bankRow [NUM_DEV];
  logic       bankValid, slotHit;
  logic [1:0] slot;
  logic [DEV_W-1:0] devIdx;

  always_comb begin
    slotHit = 1'b1;
    slot    = 2'd0;
    unique case (idxReg)
      IDX_DEV_EN:  slot = 2'd0;
      IDX_BASE_HI: slot = 2'd1;
      IDX_BASE_LO: slot = 2'd2;
      IDX_IRQ_SEL: slot = 2'd3;
      default:     slotHit = 1'b0;
    endcase
  end

  assign bankValid = (int'(devSel) < NUM_DEV);
  assign devIdx    = devSel[DEV_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxReg  <= 8'h00;
      devSel  <= 8'h00;
      portSel <= PORT_SEL_RST;
    end else begin
      if (strb.idxLoad) idxReg <= busWdata;
      if (strb.dataWr && idxReg == IDX_DEVSEL)  devSel  <= busWdata;
      if (strb.dataWr && idxReg == IDX_PORTSEL) portSel <= busWdata;
    end
  end

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_bank
    for (genvar s = 0; s < BANK_SLOTS; s++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rstN) bankRow[d][s] <= 8'h00;
        else if (strb.dataWr && bankValid && slotHit &&
                 int'(devSel) == d && int'(slot) == s)
          bankRow[d][s] <= busWdata;
      end
    end
  end

  always_comb begin
    busRdata = 8'hFF;
    if (busRd && strb.open) begin
      if (!busAddr) busRdata = idxReg;
      else if (idxReg < IDX_BANK_LO) begin
        unique case (idxReg)
          IDX_DEVSEL:  busRdata = devSel;
          IDX_CHIP_HI: busRdata = CHIP_ID[15:8];
          IDX_CHIP_LO: busRdata = CHIP_ID[7:0];
          IDX_VEND_HI: busRdata = VENDOR_ID[15:8];
          IDX_VEND_LO: busRdata = VENDOR_ID[7:0];
          IDX_PORTSEL: busRdata = portSel;
          default:     busRdata = 8'h00;
        endcase
      end
      else if (!bankValid) busRdata = 8'hFF;
      else if (slotHit)    busRdata = bankRow[devIdx][slot];
      else                 busRdata = 8'h00;
    end
  end
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
  import cfgport_pkg::*;
#(
  parameter int          NUM_DEV      = 4,
  parameter logic [7:0]  UNLOCK_KEY   = 8'h87,
  parameter logic [7:0]  LOCK_KEY     = 8'hAA,
  parameter logic [15:0] CHIP_ID      = 16'h3C15,
  parameter logic [15:0] VENDOR_ID    = 16'h5A70,
  parameter logic [7:0]  PORT_SEL_RST = 8'h00
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busAddr,
  input  logic       busWr,
  input  logic       busRd,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata
);
  cfg_strobe_t strb;
  logic cfgOpen;

  cfg_ctrl #(.UNLOCK_KEY(UNLOCK_KEY), .LOCK_KEY(LOCK_KEY)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .strb(strb)
  );

  cfg_regs #(.NUM_DEV(NUM_DEV), .CHIP_ID(CHIP_ID), .VENDOR_ID(VENDOR_ID),
             .PORT_SEL_RST(PORT_SEL_RST)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .busAddr(busAddr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata)
  );

  assign cfgOpen = strb.open;
endmodule

// File: rtl/cfg_index_port_chk.sv
module cfg_index_port_chk #(
  parameter logic [7:0] UNLOCK_KEY = 8'h87,
  parameter logic [7:0] LOCK_KEY   = 8'hAA
) (
  input logic       clk,
  input logic       rstN,
  input logic       busAddr,
  input logic       busWr,
  input logic       busRd,
  input logic [7:0] busWdata,
  input logic [7:0] busRdata,
  input logic       cfgOpen
);
  // R1: opening is always preceded by a key write on the index port
  a_r1_open_after_key: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgOpen) |-> $past(busWr && !busAddr && busWdata == UNLOCK_KEY));

  // R2: without an index-port write the closed port cannot open
  a_r2_no_spurious_open: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgOpen && !(busWr && !busAddr)) |=> !cfgOpen);

  // R3: lock key closes the port
  a_r3_lock_closes: assert property (@(posedge clk) disable iff (!rstN)
    (cfgOpen && busWr && !busAddr && busWdata == LOCK_KEY) |=> !cfgOpen);

  // R4: closed port reads all ones
  a_r4_locked_reads_ff: assert property (@(posedge clk) disable iff (!rstN)
    !cfgOpen |-> busRdata == 8'hFF);

  // R11: idle read strobe floats high, reads leave state untouched
  a_r11_idle_ff: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |-> busRdata == 8'hFF);

  a_r11_read_no_effect: assert property (@(posedge clk) disable iff (!rstN)
    !busWr |=> (!(busAddr == $past(busAddr) && busRd == $past(busRd)) || $stable(busRdata)));
endmodule

bind cfg_index_port cfg_index_port_chk #(.UNLOCK_KEY(UNLOCK_KEY), .LOCK_KEY(LOCK_KEY)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
  .busWdata(busWdata), .busRdata(busRdata), .cfgOpen(cfgOpen)
);

// File: tb/sim_cfg_index_port.sv
module sim_cfg_index_port;
  localparam int NDEV = 4;
  localparam logic [15:0] CHIP = 16'h3C15;
  localparam logic [15:0] VEND = 16'h5A70;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busAddr = 1'b0, busWr = 1'b0, busRd = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;

  int compared = 0, mismatched = 0;
  bit finished = 0;

  // behavioural model
  int mSt = 0;           // 0 locked, 1 one key seen, 2 open
  int mIdx = 0, mDev = 0, mPort = 0;
  int mBank [NDEV][4];

  cfg_index_port #(.NUM_DEV(NDEV), .CHIP_ID(CHIP), .VENDOR_ID(VEND)) u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata)
  );

  always #5 clk = ~clk;

  function automatic int slotOf(int i);
    case (i)
      'h30: return 0;
      'h60: return 1;
      'h61: return 2;
      'h70: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic int modelRead(bit a, bit rd);
    if (!rd || mSt != 2) return 'hFF;
    if (!a) return mIdx;
    if (mIdx < 'h30) begin
      case (mIdx)
        'h07: return mDev;
        'h20: return CHIP[15:8];
        'h21: return CHIP[7:0];
        'h23: return VEND[15:8];
        'h24: return VEND[7:0];
        'h26: return mPort;
        default: return 0;
      endcase
    end
    if (mDev >= NDEV) return 'hFF;
    if (slotOf(mIdx) < 0) return 0;
    return mBank[mDev][slotOf(mIdx)];
  endfunction

  task automatic modelUpdate(bit a, bit wr, int d);
    if (!wr) return;
    if (!a) begin
      if (mSt == 0) mSt = (d == 'h87) ? 1 : 0;
      else if (mSt == 1) mSt = (d == 'h87) ? 2 : 0;
      else if (d == 'hAA) mSt = 0;
      else mIdx = d;
    end else begin
      if (mSt == 1) mSt = 0;
      else if (mSt == 2) begin
        if (mIdx == 'h07) mDev = d;
        else if (mIdx == 'h26) mPort = d;
        else if (mIdx >= 'h30 && mDev < NDEV && slotOf(mIdx) >= 0)
          mBank[mDev][slotOf(mIdx)] = d;
      end
    end
  endtask

  task automatic check(int act, int exp, string tag);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // one bus cycle; compares against the model every clock
  task automatic step(bit a, bit wr, int d, string tag);
    @(negedge clk);
    busAddr = a; busWr = wr; busRd = !wr; busWdata = 8'(d);
    #1;
    check(int'(busRdata), modelRead(a, !wr), tag);
    @(posedge clk);
    modelUpdate(a, wr, d);
  endtask

  // read with an independent literal expectation as well
  task automatic rdExp(bit a, int exp, string tag);
    step(a, 1'b0, 0, tag);
    check(int'(busRdata), exp, tag);
  endtask

  task automatic wrReg(int idx, int val, string tag);
    step(1'b0, 1'b1, idx, tag);
    step(1'b1, 1'b1, val, tag);
  endtask

  task automatic unlock();
    step(1'b0, 1'b1, 'h87, "R1");
    step(1'b0, 1'b1, 'h87, "R1");
  endtask

  initial begin
    for (int d = 0; d < NDEV; d++)
      for (int s = 0; s < 4; s++) mBank[d][s] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R12 reset state
    rdExp(1'b1, 'hFF, "R12");
    rdExp(1'b0, 'hFF, "R12");

    // R2 broken sequences
    step(1'b0, 1'b1, 'h87, "R2");
    step(1'b0, 1'b1, 'h55, "R2");
    step(1'b0, 1'b1, 'h87, "R2");
    rdExp(1'b0, 'hFF, "R1");
    step(1'b1, 1'b1, 'h11, "R2");
    step(1'b0, 1'b1, 'h87, "R2");
    rdExp(1'b0, 'hFF, "R2");
    step(1'b0, 1'b1, 'h87, "R1");
    rdExp(1'b0, 'h00, "R5");

    // R6 global identifiers, read-only
    wrReg('h20, 'h99, "R6");
    rdExp(1'b1, CHIP[15:8], "R6");
    step(1'b0, 1'b1, 'h21, "R6"); rdExp(1'b1, CHIP[7:0], "R6");
    rdExp(1'b0, 'h21, "R5");
    step(1'b0, 1'b1, 'h23, "R6"); rdExp(1'b1, VEND[15:8], "R6");
    step(1'b0, 1'b1, 'h24, "R6"); rdExp(1'b1, VEND[7:0], "R6");
    wrReg('h26, 'h5C, "R6"); rdExp(1'b1, 'h5C, "R6");

    // R7 R8 banked registers
    for (int d = 0; d < NDEV; d++) begin
      wrReg('h07, d, "R7");
      wrReg('h30, 'h01 + d, "R8");
      wrReg('h60, 'h10 + d, "R8");
      wrReg('h61, 'hA0 + d, "R8");
      wrReg('h70, 'hF0 + d, "R8");
    end
    for (int d = NDEV - 1; d >= 0; d--) begin
      wrReg('h07, d, "R7");
      step(1'b0, 1'b1, 'h30, "R8"); rdExp(1'b1, 'h01 + d, "R8");
      step(1'b0, 1'b1, 'h60, "R8"); rdExp(1'b1, 'h10 + d, "R8");
      step(1'b0, 1'b1, 'h61, "R8"); rdExp(1'b1, 'hA0 + d, "R8");
      step(1'b0, 1'b1, 'h70, "R8"); rdExp(1'b1, 'hF0 + d, "R8");
      step(1'b0, 1'b1, 'h26, "R6"); rdExp(1'b1, 'h5C, "R6");
    end

    // R10 unimplemented indices
    wrReg('h31, 'h77, "R10"); rdExp(1'b1, 'h00, "R10");
    wrReg('h10, 'h66, "R10"); rdExp(1'b1, 'h00, "R10");

    // R9 out-of-range device
    wrReg('h07, 'h09, "R9");
    step(1'b0, 1'b1, 'h60, "R9"); rdExp(1'b1, 'hFF, "R9");
    step(1'b1, 1'b1, 'h42, "R9");
    wrReg('h07, 'h01, "R9");
    step(1'b0, 1'b1, 'h60, "R9"); rdExp(1'b1, 'h11, "R9");

    // R11 repeated reads and idle strobe
    rdExp(1'b1, 'h11, "R11"); rdExp(1'b1, 'h11, "R11");
    @(negedge clk); busRd = 1'b0; busWr = 1'b0; #1;
    check(int'(busRdata), 'hFF, "R11");

    // R3 R4 lock, then writes while locked
    step(1'b0, 1'b1, 'hAA, "R3");
    rdExp(1'b1, 'hFF, "R3");
    rdExp(1'b0, 'hFF, "R4");
    step(1'b1, 1'b1, 'h3E, "R4");
    unlock();
    rdExp(1'b0, 'h60, "R4");
    rdExp(1'b1, 'h11, "R4");

    // R2 data write between keys after a lock
    step(1'b0, 1'b1, 'hAA, "R3");
    step(1'b0, 1'b1, 'h87, "R2");
    step(1'b1, 1'b1, 'h00, "R2");
    step(1'b0, 1'b1, 'h87, "R2");
    rdExp(1'b1, 'hFF, "R2");

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule